// File: doc/BRIEF.md
# DRAM Low-Power Mode Controller

This block owns the clock-enable pin of a DDR2-style memory and moves the memory between normal operation, precharge/active power-down and self-refresh. A host-side power manager raises a power-down or self-refresh entry request. The block accepts an entry request only while the command path reports itself idle. For self-refresh it first issues a one-cycle self-refresh command strobe with clock-enable still high, and then it drops clock-enable. For power-down it drops clock-enable directly.

An exit request raises clock-enable again. The block then holds two independent ready flags low. One flag gates read commands and the other gates every non-read command. Each flag is released by its own down-counter. The counter is loaded from runtime delay inputs picked by the kind of exit:

- Self-refresh exit uses separate read and non-read delays.
- Power-down exit uses the common exit delay for non-read commands.
- For reads after power-down, a configuration bit selects either a fast-exit delay or a slow-exit delay.

The command scheduler simply waits for the flag that matches the command it wants to send.

Top module: `dram_lp_ctrl`

## Requirements
- R1: After reset the block is in normal operation: `cke`=1, `sr_cmd`=0, `rdy_rd`=1, `rdy_other`=1.
- R2: A self-refresh request seen at a clock edge with `cmd_idle`=1 in normal operation makes `sr_cmd` high for exactly the following cycle, with `cke` still high and both ready flags low in that cycle; `cke` is low from the cycle after the strobe.
- R3: A power-down request accepted the same way drops `cke` and both ready flags in the next cycle, and `sr_cmd` stays low.
- R4: Entry requests seen while `cmd_idle`=0 are ignored: `cke`, `sr_cmd` and both ready flags keep their normal-operation values.
- R5: When self-refresh and power-down requests are both present at an accepting edge, self-refresh wins (a `sr_cmd` pulse follows).
- R6: An exit request in self-refresh raises `cke` in the next cycle; `rdy_other` rises `t_sr_other`+1 edges and `rdy_rd` rises `t_sr_read`+1 edges after the edge that saw the exit request.
- R7: An exit request in power-down with `cfg_slow_exit`=0 raises `cke` in the next cycle; `rdy_other` rises `t_pd_any`+1 edges and `rdy_rd` rises `t_pd_rd_fast`+1 edges after the exit edge.
- R8: With `cfg_slow_exit`=1 at the exit edge, the read flag after power-down instead rises `t_pd_rd_slow`+1 edges after the exit edge.
- R9: An exit request in normal operation is ignored: `cke` and both ready flags stay high.
- R10: Entry requests during the exit wait are ignored: `cke` stays high, no `sr_cmd` pulse appears, and the flags rise at their normal times.
- R11: While in power-down or self-refresh without an exit request, `cke`, `rdy_rd` and `rdy_other` stay low.
- R12: A delay input of zero releases its flag on the first edge after the exit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_req | input | 1 | Request to enter self-refresh |
| pd_req | input | 1 | Request to enter power-down |
| exit_req | input | 1 | Request to leave power-down or self-refresh |
| cmd_idle | input | 1 | Command path has nothing in flight |
| cfg_slow_exit | input | 1 | 1 selects the slow power-down exit delay for reads |
| t_sr_other | input | DLY_W | Cycles after self-refresh exit before a non-read command |
| t_sr_read | input | DLY_W | Cycles after self-refresh exit before a read |
| t_pd_any | input | DLY_W | Cycles after power-down exit before a non-read command |
| t_pd_rd_fast | input | DLY_W | Read delay after power-down, fast exit |
| t_pd_rd_slow | input | DLY_W | Read delay after power-down, slow exit |
| cke | output | 1 | Memory clock enable |
| sr_cmd | output | 1 | One-cycle self-refresh command strobe |
| rdy_rd | output | 1 | A read command may be issued |
| rdy_other | output | 1 | A non-read command may be issued |

## Verification
The exit timing is tried with three delay sets: self-refresh exit with a long read delay and a shorter non-read delay, power-down with fast reads, and power-down with slow reads. Together these show that each flag follows its own counter and that the right delay input is picked for each exit kind. Zero delays separate an off-by-one in the counter from correct release on the first edge. Requests are also placed where they must be ignored: entry while the path is busy, exit while active, and entry during the exit wait. Simultaneous entry requests expose the priority order.

// File: rtl/dram_lp_pkg.sv
package dram_lp_pkg;

  typedef enum logic [2:0] {
    LP_ACTIVE    = 3'd0,
    LP_PD_ENTRY  = 3'd1,
    LP_PD        = 3'd2,
    LP_SR_ENTRY  = 3'd3,
    LP_SR        = 3'd4,
    LP_EXIT_WAIT = 3'd5
  } lp_state_e;

  // timer slots
  localparam int TMR_OTHER = 0;
  localparam int TMR_READ  = 1;
  localparam int NUM_TMR   = 2;

endpackage

// File: rtl/dram_lp_fsm.sv
module dram_lp_fsm
  import dram_lp_pkg::*;
#(
  parameter int NUM_T = NUM_TMR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sr_req,
  input  logic             pd_req,
  input  logic             exit_req,
  input  logic             cmd_idle,
  input  logic [NUM_T-1:0] tmr_done,
  output lp_state_e        state,
  output logic             accept_enter,
  output logic             load_exit
);

  lp_state_e state_nxt;
  logic      all_done;

  assign all_done = &tmr_done;

  always_comb begin
    state_nxt    = state;
    accept_enter = 1'b0;
    load_exit    = 1'b0;
    unique case (state)
      LP_ACTIVE: begin
        if (cmd_idle && sr_req) begin
          state_nxt    = LP_SR_ENTRY;
          accept_enter = 1'b1;
        end else if (cmd_idle && pd_req) begin
          state_nxt    = LP_PD_ENTRY;
          accept_enter = 1'b1;
        end
      end
      LP_SR_ENTRY: state_nxt = LP_SR;
      LP_PD_ENTRY: state_nxt = LP_PD;
      LP_SR, LP_PD: begin
        if (exit_req) begin
          state_nxt = LP_EXIT_WAIT;
          load_exit = 1'b1;
        end
      end
      LP_EXIT_WAIT: begin
        if (all_done) state_nxt = LP_ACTIVE;
      end
      default: state_nxt = LP_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LP_ACTIVE;
    else        state <= state_nxt;
  end

endmodule

// File: rtl/dram_lp_exit_timer.sv
module dram_lp_exit_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             counting,
  input  logic             hold_ready,
  output logic             done,
  output logic             rdy
);

  logic [DLY_W-1:0] cnt;
  logic [DLY_W-1:0] cnt_nxt;
  logic             cnt_en;
  logic             rdy_nxt;

  assign done    = (cnt == '0);
  assign cnt_en  = load | (counting & ~done);
  assign cnt_nxt = load ? load_val : (cnt - 1'b1);
  assign rdy_nxt = hold_ready | (counting & done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy <= 1'b1;
    else        rdy <= rdy_nxt;
  end

endmodule

// File: rtl/dram_lp_ctrl.sv
module dram_lp_ctrl
  import dram_lp_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sr_req,
  input  logic             pd_req,
  input  logic             exit_req,
  input  logic             cmd_idle,
  input  logic             cfg_slow_exit,
  input  logic [DLY_W-1:0] t_sr_other,
  input  logic [DLY_W-1:0] t_sr_read,
  input  logic [DLY_W-1:0] t_pd_any,
  input  logic [DLY_W-1:0] t_pd_rd_fast,
  input  logic [DLY_W-1:0] t_pd_rd_slow,
  output logic             cke,
  output logic             sr_cmd,
  output logic             rdy_rd,
  output logic             rdy_other
);

  lp_state_e          state;
  logic               accept_enter;
  logic               load_exit;
  logic               from_sr;
  logic               counting;
  logic               hold_ready;
  logic [NUM_TMR-1:0] tmr_done;
  logic [NUM_TMR-1:0] tmr_rdy;
  logic [DLY_W-1:0]   tmr_load [NUM_TMR];
  logic [DLY_W-1:0]   pd_rd_dly;

  dram_lp_fsm #(.NUM_T(NUM_TMR)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sr_req       (sr_req),
    .pd_req       (pd_req),
    .exit_req     (exit_req),
    .cmd_idle     (cmd_idle),
    .tmr_done     (tmr_done),
    .state        (state),
    .accept_enter (accept_enter),
    .load_exit    (load_exit)
  );

  // delay selection by exit kind
  assign from_sr   = (state == LP_SR);
  assign pd_rd_dly = cfg_slow_exit ? t_pd_rd_slow : t_pd_rd_fast;
  assign tmr_load[TMR_OTHER] = from_sr ? t_sr_other : t_pd_any;
  assign tmr_load[TMR_READ]  = from_sr ? t_sr_read  : pd_rd_dly;

  assign counting   = (state == LP_EXIT_WAIT);
  assign hold_ready = (state == LP_ACTIVE) & ~accept_enter;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    dram_lp_exit_timer #(.DLY_W(DLY_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_exit),
      .load_val   (tmr_load[g]),
      .counting   (counting),
      .hold_ready (hold_ready),
      .done       (tmr_done[g]),
      .rdy        (tmr_rdy[g])
    );
  end

  assign cke       = (state == LP_ACTIVE) | (state == LP_SR_ENTRY) |
                     (state == LP_EXIT_WAIT);
  assign sr_cmd    = (state == LP_SR_ENTRY);
  assign rdy_rd    = tmr_rdy[TMR_READ];
  assign rdy_other = tmr_rdy[TMR_OTHER];

endmodule

// File: rtl/dram_lp_ctrl_chk.sv
module dram_lp_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_idle,
  input logic exit_req,
  input logic cke,
  input logic sr_cmd,
  input logic rdy_rd,
  input logic rdy_other
);

  // R2: strobe lasts one cycle and clock enable drops after it
  a_r2_strobe_then_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    sr_cmd |=> (!sr_cmd && !cke));

  // R2: clock enable is high while the strobe is out
  a_r2_cke_high_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sr_cmd |-> cke);

  // R11: no command may be released while clock enable is low
  a_r11_no_ready_when_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!rdy_rd && !rdy_other));

  // R6: clock enable only returns through an exit request
  a_r6_cke_rise_needs_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(exit_req));

  // R4: self-refresh strobe only follows an idle command path
  a_r4_strobe_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_cmd) |-> $past(cmd_idle));

  // R4: direct clock-enable drop (power-down) only follows an idle path
  a_r4_pd_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cke) && !$past(sr_cmd)) |-> $past(cmd_idle));

  // R9: exit request in normal operation leaves everything up
  a_r9_exit_ignored_active: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && rdy_rd && rdy_other && exit_req && !cmd_idle) |=>
      (cke && rdy_rd && rdy_other));

  // R10: during the exit wait, clock enable stays up and no strobe appears
  a_r10_wait_holds_cke: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !sr_cmd && !(rdy_rd && rdy_other)) |=> (cke && !sr_cmd));

endmodule

bind dram_lp_ctrl dram_lp_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_idle  (cmd_idle),
  .exit_req  (exit_req),
  .cke       (cke),
  .sr_cmd    (sr_cmd),
  .rdy_rd    (rdy_rd),
  .rdy_other (rdy_other)
);

// File: tb/dram_lp_ctrl_tb_top.sv
module dram_lp_ctrl_tb_top;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sr_req, pd_req, exit_req, cmd_idle, cfg_slow_exit;
  logic [DW-1:0] t_sr_other, t_sr_read, t_pd_any, t_pd_rd_fast, t_pd_rd_slow;
  logic          cke, sr_cmd, rdy_rd, rdy_other;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dram_lp_ctrl #(.DLY_W(DW)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sr_req        (sr_req),
    .pd_req        (pd_req),
    .exit_req      (exit_req),
    .cmd_idle      (cmd_idle),
    .cfg_slow_exit (cfg_slow_exit),
    .t_sr_other    (t_sr_other),
    .t_sr_read     (t_sr_read),
    .t_pd_any      (t_pd_any),
    .t_pd_rd_fast  (t_pd_rd_fast),
    .t_pd_rd_slow  (t_pd_rd_slow),
    .cke           (cke),
    .sr_cmd        (sr_cmd),
    .rdy_rd        (rdy_rd),
    .rdy_other     (rdy_other)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // outputs packed as {cke, sr_cmd, rdy_rd, rdy_other}
  function automatic int outs();
    return {28'd0, cke, sr_cmd, rdy_rd, rdy_other};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; sr_req = 0; pd_req = 0; exit_req = 0; cmd_idle = 1; cfg_slow_exit = 0;
    t_sr_other = 8'd16; t_sr_read = 8'd200; t_pd_any = 8'd2;
    t_pd_rd_fast = 8'd2; t_pd_rd_slow = 8'd7;
    repeat (3) step();
    check("R1", "outputs in reset", outs(), 4'b1011);
    rst_n = 1'b1;
    step();
    check("R1", "outputs after reset", outs(), 4'b1011);
  endtask

  task automatic t_enter_sr(input bit with_pd);
    sr_req = 1; pd_req = with_pd; cmd_idle = 1;
    step();
    sr_req = 0; pd_req = 0;
    check(with_pd ? "R5" : "R2", "strobe cycle outputs", outs(), 4'b1100);
    step();
    check("R2", "after strobe", outs(), 4'b0000);
    for (int i = 0; i < 5; i++) begin
      step();
      check("R11", "held in self-refresh", outs(), 4'b0000);
    end
  endtask

  task automatic t_enter_pd();
    pd_req = 1; cmd_idle = 1;
    step();
    pd_req = 0;
    check("R3", "power-down entry", outs(), 4'b0000);
    for (int i = 0; i < 4; i++) begin
      step();
      check("R11", "held in power-down", outs(), 4'b0000);
    end
  endtask

  // exit and measure release edges; edge 0 is the one that saw exit_req
  task automatic t_exit(input string req, input int exp_oth, input int exp_rd, input bit pressure);
    int oth_at = -1;
    int rd_at  = -1;
    int bad_cke = 0;
    exit_req = 1;
    step();
    exit_req = 0;
    check(req, "cke after exit edge", int'(cke), 1);
    if (exp_oth != 0) check(req, "rdy_other right after exit", int'(rdy_other), 0);
    if (pressure) begin sr_req = 1; pd_req = 1; cmd_idle = 1; end
    for (int m = 1; m <= 300 && (oth_at < 0 || rd_at < 0); m++) begin
      step();
      if (!cke || sr_cmd) bad_cke++;
      if (rdy_other && oth_at < 0) oth_at = m;
      if (rdy_rd && rd_at < 0) rd_at = m;
      if (rdy_rd && rdy_other) begin sr_req = 0; pd_req = 0; end
    end
    sr_req = 0; pd_req = 0;
    check(req, "rdy_other release edge", oth_at, exp_oth + 1);
    check(req, "rdy_rd release edge", rd_at, exp_rd + 1);
    if (pressure) check("R10", "cke drop or strobe during wait", bad_cke, 0);
    step();
    check(req, "normal operation after exit", outs(), 4'b1011);
  endtask

  task automatic t_busy_ignore();
    cmd_idle = 0; sr_req = 1; pd_req = 1;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R4", "request while busy", outs(), 4'b1011);
    end
    sr_req = 0; pd_req = 0; cmd_idle = 1;
    step();
    check("R4", "still active", outs(), 4'b1011);
  endtask

  task automatic t_exit_in_active();
    exit_req = 1; cmd_idle = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R9", "exit in active", outs(), 4'b1011);
    end
    exit_req = 0; cmd_idle = 1;
    // a following power-down must still behave normally
    t_enter_pd();
    t_exit("R9", 2, 2, 0);
  endtask

  initial begin
    t_reset();
    t_busy_ignore();
    t_exit_in_active();
    // R2, R6: self-refresh entry and exit
    t_enter_sr(0);
    t_exit("R6", 16, 200, 0);
    // R3, R7: power-down, fast exit
    t_enter_pd();
    cfg_slow_exit = 0;
    t_exit("R7", 2, 2, 0);
    // R8: slow exit
    t_enter_pd();
    cfg_slow_exit = 1;
    t_exit("R8", 2, 7, 0);
    cfg_slow_exit = 0;
    // R5: priority, then R10: requests during exit wait
    t_enter_sr(1);
    t_sr_other = 8'd5; t_sr_read = 8'd30;
    t_exit("R10", 5, 30, 1);
    // R12: zero delays
    t_enter_pd();
    t_pd_any = 8'd0; t_pd_rd_fast = 8'd0;
    t_exit("R12", 0, 0, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule